// File: doc/BRIEF.md
# Measurement Conversion Sequencer with Averaging

This block drives an external converter through the three measurement channels of a current monitor: shunt voltage, bus voltage and die temperature. For each enabled channel it issues a start pulse, tells the converter how many clock cycles that channel's conversion lasts, and takes the sample back on the converter's done pulse. Samples go into one accumulator per channel. The channel sequence repeats until the selected number of averages has been collected. Only then are the averaged values written to the readable result registers and the ready flag raised.

Software writes a single 16-bit configuration word. The word selects the enabled channels, continuous or single-shot operation, one conversion-time select per channel and the averaging select. Writing a word with no channel enabled puts the block in shutdown. In single-shot operation every non-shutdown write starts one full averaged pass, even when the word written is the same as before. The ready flag is cleared by a status read and by any configuration write that does not select shutdown.

Top module: `meas_seq`

## Requirements
- R1: After reset all three results read 0, `rdy` is 0 and no `cnv_start` is issued until a configuration write.
- R2: Configuration word fields are: bits [2:0] enable shunt (bit 0), bus (bit 1) and temperature (bit 2); bit 3 selects continuous (1) or single-shot (0); bits [6:4], [9:7] and [12:10] are the shunt, bus and temperature time selects; bits [15:13] are the averaging select. All enable bits zero means shutdown.
- R3: While channel `cnv_ch` converts (code 0 shunt, 1 bus, 2 temperature), `cnv_len` equals CT_BASE shifted left by that channel's time select and stays constant until the conversion ends.
- R4: The first `cnv_start` comes in the cycle after a non-shutdown configuration write. Within a round, enabled channels are converted in ascending code order. Each following `cnv_start` comes in the cycle right after the `cnv_done` that ended the previous conversion, so a conversion of length L takes exactly L+1 cycles.
- R5: Averaging select values 0..7 give 1, 4, 16, 64, 128, 256, 512 and 1024 samples per channel. Each result is the floor of the sample sum divided by the count. Shunt samples are signed 20-bit, bus samples are unsigned 20-bit, and temperature samples are the signed low 16 bits of `cnv_data`.
- R6: Results change only in the cycle after the final `cnv_done` of a pass, and `rdy` rises in that same cycle. The results of disabled channels keep their values.
- R7: In single-shot operation no `cnv_start` follows the completion of a pass.
- R8: In single-shot operation, rewriting an unchanged configuration word starts a new full pass.
- R9: In continuous operation the next pass starts right after the final `cnv_done`, with freshly cleared accumulators, and publishes its own results.
- R10: `rdy` clears the cycle after a `stat_rd` or a non-shutdown configuration write. If a publish happens in the same cycle as a read, `rdy` stays set.
- R11: A shutdown write aborts any conversion in progress and stops further starts; it leaves `rdy` and the results unchanged.
- R12: A `cnv_done` pulse while the block is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 16 | Configuration word |
| stat_rd | input | 1 | Status read strobe, clears `rdy` |
| cnv_start | output | 1 | One-cycle converter start pulse |
| cnv_ch | output | 2 | Channel being converted |
| cnv_len | output | LEN_W (12) | Conversion length in clock cycles |
| cnv_done | input | 1 | Converter done pulse, sample valid |
| cnv_data | input | SMP_W (20) | Converter sample |
| res_shunt | output | SMP_W (20) | Averaged shunt result, signed |
| res_bus | output | SMP_W (20) | Averaged bus result, unsigned |
| res_temp | output | TMP_W (16) | Averaged temperature result, signed |
| rdy | output | 1 | Conversion-ready flag |

## Verification
The bench runs single-shot passes over all seven enable combinations, crossed with the three shortest averaging counts and rotating time selects. It then runs one channel through every averaging count up to 1024. Changes in the enable set show whether the channel order, the per-channel length selection and the hold of disabled results are right. The spread of averaging counts separates a wrong shift amount from a wrong round count. A converter model returns pseudo-random samples of both signs, so floor rounding and sign or zero extension each show up as a mismatch. Pass latency is compared with the sum of the lengths plus one cycle per conversion, which exposes any idle gap. Continuous, rewrite, shutdown and stray-done cases then test the control behaviour on its own.

// File: rtl/meas_pkg.sv
package meas_pkg;

  localparam int NCH    = 3;
  localparam int MAX_SH = 10;
  localparam int CNT_W  = MAX_SH + 1;

  localparam logic [1:0] CH_SHUNT = 2'd0;
  localparam logic [1:0] CH_BUS   = 2'd1;
  localparam logic [1:0] CH_TEMP  = 2'd2;

  typedef struct packed {
    logic [2:0] avg_sel;
    logic [2:0] ts_temp;
    logic [2:0] ts_bus;
    logic [2:0] ts_shunt;
    logic       cont;
    logic [2:0] en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // averaging select -> log2 of the sample count
  function automatic logic [3:0] avg_shift(input logic [2:0] s);
    case (s)
      3'd0:    return 4'd0;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      default: return {1'b0, s} + 4'd3;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] avg_count(input logic [2:0] s);
    return CNT_W'(1) << avg_shift(s);
  endfunction

  function automatic logic [1:0] first_chan(input logic [2:0] en);
    if (en[0]) return CH_SHUNT;
    if (en[1]) return CH_BUS;
    return CH_TEMP;
  endfunction

  // {valid, channel} of the next enabled channel after ch in this round
  function automatic logic [2:0] next_chan(input logic [2:0] en, input logic [1:0] ch);
    case (ch)
      CH_SHUNT: begin
        if (en[1]) return {1'b1, CH_BUS};
        if (en[2]) return {1'b1, CH_TEMP};
        return 3'b000;
      end
      CH_BUS: begin
        if (en[2]) return {1'b1, CH_TEMP};
        return 3'b000;
      end
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/meas_acc.sv
module meas_acc #(
  parameter int IN_W      = 20,
  parameter int ACC_W     = 30,
  parameter bit SIGNED_IN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [IN_W-1:0]  din,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W-1:0] ext;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  generate
    if (SIGNED_IN) begin : g_sext
      assign ext = {{(ACC_W-IN_W){din[IN_W-1]}}, din};
    end else begin : g_zext
      assign ext = {{(ACC_W-IN_W){1'b0}}, din};
    end
  endgenerate

  always_comb begin
    acc_en = clr | add;
    if (clr) acc_d = add ? ext : '0;
    else     acc_d = acc + ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (acc_en) acc <= acc_d;
  end

  // a clear leaves only the sample taken with it
  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !add) |=> (acc == '0)); // R9

endmodule

// File: rtl/meas_fsm.sv
module meas_fsm
  import meas_pkg::*;
#(
  parameter int CT_BASE = 2,
  parameter int LEN_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  cfg_t             cfg_in,
  input  logic             cnv_done,
  output cfg_t             cfg_q,
  output logic             cnv_start,
  output logic [1:0]       cnv_ch,
  output logic [LEN_W-1:0] cnv_len,
  output logic             acc_add,
  output logic             acc_clr,
  output logic             pub,
  output logic             run_wr
);

  logic             busy_q, busy_d;
  logic [1:0]       ch_d;
  logic [CNT_W-1:0] rnd_q, rnd_d;
  logic             start_d;
  logic             pub_q, pub_d;
  logic             shdn_wr;
  logic             take;
  logic             last_rnd;
  logic [2:0]       nxt;
  logic [2:0]       tsel;

  // next-state logic
  always_comb begin
    shdn_wr  = cfg_wr && (cfg_in.en == 3'b000);
    run_wr   = cfg_wr && !shdn_wr;
    take     = busy_q && cnv_done && !cfg_wr;
    nxt      = next_chan(cfg_q.en, cnv_ch);
    last_rnd = ((rnd_q + CNT_W'(1)) == avg_count(cfg_q.avg_sel));

    busy_d  = busy_q;
    ch_d    = cnv_ch;
    rnd_d   = rnd_q;
    start_d = 1'b0;
    pub_d   = 1'b0;

    if (run_wr) begin
      busy_d  = 1'b1;
      ch_d    = first_chan(cfg_in.en);
      rnd_d   = '0;
      start_d = 1'b1;
    end else if (shdn_wr) begin
      busy_d = 1'b0;
    end else if (take) begin
      if (nxt[2]) begin
        ch_d    = nxt[1:0];
        start_d = 1'b1;
      end else if (last_rnd) begin
        pub_d = 1'b1;
        rnd_d = '0;
        ch_d  = first_chan(cfg_q.en);
        if (cfg_q.cont) start_d = 1'b1;
        else            busy_d  = 1'b0;
      end else begin
        rnd_d   = rnd_q + CNT_W'(1);
        ch_d    = first_chan(cfg_q.en);
        start_d = 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      busy_q    <= 1'b0;
      cnv_ch    <= 2'd0;
      rnd_q     <= '0;
      cnv_start <= 1'b0;
      pub_q     <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_in;
      busy_q    <= busy_d;
      cnv_ch    <= ch_d;
      rnd_q     <= rnd_d;
      cnv_start <= start_d;
      pub_q     <= pub_d;
    end
  end

  always_comb begin
    case (cnv_ch)
      CH_SHUNT: tsel = cfg_q.ts_shunt;
      CH_BUS:   tsel = cfg_q.ts_bus;
      default:  tsel = cfg_q.ts_temp;
    endcase
    cnv_len = LEN_W'(CT_BASE) << tsel;
    acc_add = take;
    acc_clr = run_wr | pub_q;
    pub     = pub_q & ~cfg_wr;
  end

  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> cfg_q.en[cnv_ch]); // R4

  AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_in.en == 3'b000) |=> !cnv_start); // R11

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cnv_done && !cfg_wr) |=> (!cnv_start && !pub_q)); // R12

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cnv_done && !cfg_wr) |=> ($stable(cnv_ch) && $stable(cnv_len))); // R3

endmodule

// File: rtl/meas_bank.sv
module meas_bank
  import meas_pkg::*;
#(
  parameter int SMP_W = 20,
  parameter int TMP_W = 16,
  parameter int ACC_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pub,
  input  logic             clr_rdy,
  input  logic             stat_rd,
  input  logic [2:0]       en,
  input  logic [2:0]       avg_sel,
  input  logic [ACC_W-1:0] acc_sh,
  input  logic [ACC_W-1:0] acc_bus,
  input  logic [ACC_W-1:0] acc_tmp,
  output logic [SMP_W-1:0] res_shunt,
  output logic [SMP_W-1:0] res_bus,
  output logic [TMP_W-1:0] res_temp,
  output logic             rdy
);

  logic [3:0]       sh;
  logic [SMP_W-1:0] shunt_d, bus_d;
  logic [TMP_W-1:0] temp_d;
  logic             rdy_d;

  always_comb begin
    sh      = avg_shift(avg_sel);
    shunt_d = SMP_W'($signed(acc_sh)  >>> sh);
    bus_d   = SMP_W'($signed(acc_bus) >>> sh);
    temp_d  = TMP_W'($signed(acc_tmp) >>> sh);
    rdy_d   = rdy;
    if (pub)                     rdy_d = 1'b1;
    else if (stat_rd || clr_rdy) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_shunt <= '0;
      res_bus   <= '0;
      res_temp  <= '0;
      rdy       <= 1'b0;
    end else begin
      if (pub && en[0]) res_shunt <= shunt_d;
      if (pub && en[1]) res_bus   <= bus_d;
      if (pub && en[2]) res_temp  <= temp_d;
      rdy <= rdy_d;
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pub |=> ($stable(res_shunt) && $stable(res_bus) && $stable(res_temp))); // R6

  AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pub |=> rdy); // R6

  AST_RDY_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !pub) |=> !rdy); // R10

endmodule

// File: rtl/meas_seq.sv
module meas_seq
  import meas_pkg::*;
#(
  parameter int SMP_W   = 20,
  parameter int TMP_W   = 16,
  parameter int CT_BASE = 2,
  parameter int LEN_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_data,
  input  logic             stat_rd,
  output logic             cnv_start,
  output logic [1:0]       cnv_ch,
  output logic [LEN_W-1:0] cnv_len,
  input  logic             cnv_done,
  input  logic [SMP_W-1:0] cnv_data,
  output logic [SMP_W-1:0] res_shunt,
  output logic [SMP_W-1:0] res_bus,
  output logic [TMP_W-1:0] res_temp,
  output logic             rdy
);

  localparam int ACC_W = SMP_W + MAX_SH;

  logic [1:0]       rst_pipe;
  logic             rst_i_n;
  cfg_t             cfg_q;
  logic             acc_add, acc_clr, pub, run_wr;
  logic [ACC_W-1:0] acc_v [NCH];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  meas_fsm #(.CT_BASE(CT_BASE), .LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cfg_wr    (cfg_wr),
    .cfg_in    (cfg_t'(cfg_data)),
    .cnv_done  (cnv_done),
    .cfg_q     (cfg_q),
    .cnv_start (cnv_start),
    .cnv_ch    (cnv_ch),
    .cnv_len   (cnv_len),
    .acc_add   (acc_add),
    .acc_clr   (acc_clr),
    .pub       (pub),
    .run_wr    (run_wr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int IW = (c == 2) ? TMP_W : SMP_W;
    localparam bit SG = (c != 1);
    logic add_c;
    assign add_c = acc_add && (cnv_ch == 2'(c));
    meas_acc #(.IN_W(IW), .ACC_W(ACC_W), .SIGNED_IN(SG)) u_acc (
      .clk   (clk),
      .rst_n (rst_i_n),
      .clr   (acc_clr),
      .add   (add_c),
      .din   (cnv_data[IW-1:0]),
      .acc   (acc_v[c])
    );
  end

  meas_bank #(.SMP_W(SMP_W), .TMP_W(TMP_W), .ACC_W(ACC_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .pub       (pub),
    .clr_rdy   (run_wr),
    .stat_rd   (stat_rd),
    .en        (cfg_q.en),
    .avg_sel   (cfg_q.avg_sel),
    .acc_sh    (acc_v[0]),
    .acc_bus   (acc_v[1]),
    .acc_tmp   (acc_v[2]),
    .res_shunt (res_shunt),
    .res_bus   (res_bus),
    .res_temp  (res_temp),
    .rdy       (rdy)
  );

endmodule

// File: tb/meas_seq_test.sv
module meas_seq_test;

  localparam int CLK_P = 10;
  localparam int CTB   = 2;

  logic        clk, rst_n, cfg_wr, stat_rd, cnv_done;
  logic [15:0] cfg_data;
  logic [19:0] cnv_data;
  logic        cnv_start, rdy;
  logic [1:0]  cnv_ch;
  logic [11:0] cnv_len;
  logic [19:0] res_shunt, res_bus;
  logic [15:0] res_temp;

  int total = 0, bad = 0, cyc = 0, nstart = 0, cyc_w = 0;
  bit finished = 0;

  // converter model and reference state
  bit          pend = 0, inject = 0;
  int          cnt = 0, conv = 0;
  int          cur_sh = 0, cur_cnt = 1, cur_nen = 1;
  logic [2:0]  cur_en = 3'b001;
  int          cur_ts [3];
  longint      sum_m [3];
  logic [19:0] m_res [3];
  logic [31:0] lcg = 32'h1234_5678;

  meas_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .stat_rd(stat_rd),
    .cnv_start(cnv_start), .cnv_ch(cnv_ch), .cnv_len(cnv_len), .cnv_done(cnv_done),
    .cnv_data(cnv_data), .res_shunt(res_shunt), .res_bus(res_bus), .res_temp(res_temp),
    .rdy(rdy)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int bshift(input int a);
    case (a)
      0: return 0; 1: return 2; 2: return 4; 3: return 6;
      4: return 7; 5: return 8; 6: return 9; default: return 10;
    endcase
  endfunction

  // converter stub: reacts one time unit after each rising edge
  initial begin
    cnv_done = 1'b0;
    cnv_data = '0;
    for (int c = 0; c < 3; c++) begin sum_m[c] = 0; m_res[c] = '0; cur_ts[c] = 0; end
    forever begin
      @(posedge clk); #1;
      cnv_done = 1'b0;
      if (cfg_wr) begin
        pend = 0; conv = 0;
        for (int c = 0; c < 3; c++) sum_m[c] = 0;
      end
      if (inject) begin
        inject = 0; cnv_done = 1'b1; cnv_data = 20'h4_5A5A;
      end else if (cnv_start) begin
        nstart++;
        pend = 1;
        cnt  = int'(cnv_len);
        chk(cnv_len == 12'(CTB << cur_ts[cnv_ch]), "R3 conversion length",
            longint'(cnv_len), longint'(CTB << cur_ts[cnv_ch]));
      end else if (pend) begin
        cnt--;
        if (cnt == 0) begin
          pend = 0;
          lcg = lcg * 32'd1664525 + 32'd1013904223;
          cnv_data = lcg[27:8];
          cnv_done = 1'b1;
          case (cnv_ch)
            2'd0:    sum_m[0] += longint'($signed(cnv_data));
            2'd1:    sum_m[1] += longint'(cnv_data);
            default: sum_m[2] += longint'($signed(cnv_data[15:0]));
          endcase
          conv++;
          if (conv == cur_cnt * cur_nen) begin
            for (int c = 0; c < 3; c++) begin
              if (cur_en[c]) m_res[c] = 20'(sum_m[c] >>> cur_sh);
              sum_m[c] = 0;
            end
            conv = 0;
          end
        end
      end
    end
  end

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_data = w;
    if (w[2:0] != 3'b000) begin
      cur_en = w[2:0];
      cur_ts[0] = int'(w[6:4]); cur_ts[1] = int'(w[9:7]); cur_ts[2] = int'(w[12:10]);
      cur_sh = bshift(int'(w[15:13]));
      cur_cnt = 1 << cur_sh;
      cur_nen = $countones(w[2:0]);
    end
    @(negedge clk);
    cfg_wr = 1'b0;
    cyc_w = cyc;
  endtask

  task automatic wait_rdy(output int lat);
    int n = 0;
    while (!rdy && n < 20000) begin @(negedge clk); n++; end
    chk(rdy, "R6 ready flag rises", longint'(rdy), 1);
    lat = cyc - cyc_w;
  endtask

  task automatic cmp_res(input string tag);
    chk(res_shunt == m_res[0], {tag, " shunt"}, longint'(res_shunt), longint'(m_res[0]));
    chk(res_bus == m_res[1], {tag, " bus"}, longint'(res_bus), longint'(m_res[1]));
    chk(res_temp == m_res[2][15:0], {tag, " temp"}, longint'(res_temp), longint'(m_res[2][15:0]));
  endtask

  task automatic read_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  // single-shot pass with latency and result checks
  task automatic run_pass(input logic [15:0] w, input string tag);
    int lat, expl;
    write_cfg(w);
    chk(!rdy, "R10 config write clears ready", longint'(rdy), 0);
    wait_rdy(lat);
    expl = 1;
    for (int c = 0; c < 3; c++)
      if (cur_en[c]) expl += cur_cnt * ((CTB << cur_ts[c]) + 1);
    chk(lat == expl, "R4 back-to-back pass latency", longint'(lat), longint'(expl));
    cmp_res(tag);
  endtask

  function automatic logic [15:0] mk(input int en, input bit cont, input int t0,
                                     input int t1, input int t2, input int a);
    return {3'(a), 3'(t2), 3'(t1), 3'(t0), cont, 3'(en)};
  endfunction

  initial begin
    int lat, ns;
    logic [19:0] s_sh, s_bus;
    logic [15:0] s_tmp;
    rst_n = 1'b0; cfg_wr = 1'b0; stat_rd = 1'b0; cfg_data = '0;
    repeat (4) @(negedge clk);
    chk(res_shunt == 0 && res_bus == 0 && res_temp == 0, "R1 results after reset",
        longint'(res_shunt | res_bus | 20'(res_temp)), 0);
    chk(!rdy, "R1 ready after reset", longint'(rdy), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(nstart == 0 && !cnv_start, "R1 no start before config", longint'(nstart), 0);

    inject = 1;
    repeat (4) @(negedge clk);
    chk(nstart == 0, "R12 idle done starts nothing", longint'(nstart), 0);
    chk(!rdy && res_shunt == 0, "R12 idle done publishes nothing", longint'(rdy), 0);

    // enable combinations x short averaging counts (R2 field layout)
    for (int a = 0; a < 3; a++)
      for (int en = 1; en < 8; en++)
        run_pass(mk(en, 1'b0, (en + a) % 3, (en + a + 1) % 3, (en + a + 2) % 3, a),
                 "R5 R6 averaged result");

    // every long averaging count on one channel
    for (int a = 3; a < 8; a++) run_pass(mk(1, 1'b0, 0, 0, 0, a), "R5 long average");

    ns = nstart;
    repeat (40) @(negedge clk);
    chk(nstart == ns, "R7 halt after single pass", longint'(nstart), longint'(ns));
    chk(rdy, "R7 ready held while halted", longint'(rdy), 1);

    read_stat();
    chk(!rdy, "R10 status read clears ready", longint'(rdy), 0);

    run_pass(mk(5, 1'b0, 1, 0, 2, 1), "R5 pass before rewrite");
    run_pass(mk(5, 1'b0, 1, 0, 2, 1), "R8 rewrite starts new pass");

    write_cfg(mk(3, 1'b1, 1, 0, 0, 1));
    wait_rdy(lat);
    cmp_res("R9 continuous first pass");
    read_stat();
    chk(!rdy, "R10 read in continuous", longint'(rdy), 0);
    wait_rdy(lat);
    cmp_res("R9 continuous second pass");
    repeat (5) @(negedge clk);

    s_sh = res_shunt; s_bus = res_bus; s_tmp = res_temp;
    write_cfg(16'h0000);
    ns = nstart;
    repeat (80) @(negedge clk);
    chk(nstart == ns, "R11 no start after shutdown", longint'(nstart), longint'(ns));
    chk(rdy, "R11 shutdown keeps ready", longint'(rdy), 1);
    chk(res_shunt == s_sh && res_bus == s_bus && res_temp == s_tmp,
        "R11 shutdown keeps results", longint'(res_shunt), longint'(s_sh));

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule